// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block takes a DDR SDRAM from power-up to the idle state. After reset it holds the clock-enable pin low for a programmable settling period. It then raises clock enable and plays a fixed list of commands with programmable gaps between them. It enables the delay-locked loop through the extended mode register and resets it through the mode register. It then precharges every bank and refreshes twice. Finally it writes the mode register again with the reset bit cleared. A done flag is raised once the DLL has had its full lock time, counted from the write that reset it.

The mode register contents come from four configuration inputs: burst length, burst ordering, CAS latency and output driver strength. These inputs must stay stable from reset release until done. Every cycle that carries no listed command drives a no-operation command. Once done is high, the memory controller takes over the command bus.

Top module: `ddr_pwrup_seq`

## Requirements
- R1: While reset is asserted, CKE is low, the command lines show NOP (chip select, RAS, CAS and WE encoded as 4'b0111), done is low, and bank address and address are zero.
- R2: Counting rising edges from reset release, CKE is low for the first T_STABLE + REG_OUT edges, then rises and stays high. Only NOP is driven while CKE is low, and CKE is high with NOP for T_CKE_NOP cycles before the first command.
- R3: The commands appear in this order: precharge-all (4'b0010), extended mode write, mode write with DLL reset, precharge-all, refresh (4'b0001), refresh, and mode write without DLL reset. Mode writes are 4'b0000. Every other cycle carries NOP.
- R4: Each command follows its predecessor by a fixed number of cycles: T_RP after a precharge, T_MRD (at least 2) after a mode write, and T_RFC (at least 2) after a refresh.
- R5: A precharge drives address bit 10 high and all other address bits low. A mode write selects bank 0 for the mode register and bank 1 for the extended mode register.
- R6: The extended mode write drives address bit 0 low (DLL enabled) and address bit 1 equal to cfg_drv_weak (0 normal, 1 weak), with all other bits low.
- R7: A mode write carries the burst-length code on bits 2..0 (cfg_burst_len 0/1/2 gives 3'b001/010/011, i.e. 2/4/8), burst type on bit 3 (cfg_burst_ilv, 1 interleaved), and the CAS-latency code on bits 6..4 (cfg_cas_lat 0/1/2 gives 3'b010/110/011, i.e. 2/2.5/3). Bit 8 is high on the first mode write and low on the second.
- R8: The unused setting cfg_burst_len = 3 encodes a burst of 8, and cfg_cas_lat = 3 encodes CAS latency 3.
- R9: Done rises at the later of T_DLL cycles after the DLL-reset mode write and T_MRD cycles after the final mode write. It then stays high, and only NOP is driven afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_burst_len | input | 2 | Burst length select: 0=2, 1=4, 2 or 3=8 |
| cfg_burst_ilv | input | 1 | Burst ordering: 0 sequential, 1 interleaved |
| cfg_cas_lat | input | 2 | CAS latency select: 0=2, 1=2.5, 2 or 3=3 |
| cfg_drv_weak | input | 1 | Output driver strength: 0 normal, 1 weak |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| mem_cke | output | 1 | Clock enable to the memory |
| mem_ba | output | BA_W | Bank address |
| mem_addr | output | ROW_W | Address bus |
| init_done | output | 1 | High once initialization is complete |

## Verification
The bound checker watches these rules on every cycle: CKE never drops once high, no command is issued while CKE is low, a mode write or refresh is always followed by a NOP, and precharge and extended-mode words have the right shape. It also checks that done never comes before three mode writes and a full DLL lock window, and that no command follows done. The exact cycle of each command, the field values decoded from each mix of settings, the mapping of the unused setting codes, and the cycle on which done rises can only be shown by the bench scenarios. The bench compares these against a timeline it builds itself.

// File: rtl/ddr_pwrup_pkg.sv
`timescale 1ns/1ps
package ddr_pwrup_pkg;

   // command encoding {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_MRS = 4'b0000,
      CMD_REF = 4'b0001,
      CMD_PRE = 4'b0010,
      CMD_NOP = 4'b0111
   } cmd_e;

   typedef enum logic [3:0] {
      ST_STABLE,
      ST_CKE,
      ST_PRE_A,
      ST_EMRS,
      ST_MRS_DLLRST,
      ST_PRE_B,
      ST_REF_A,
      ST_REF_B,
      ST_MRS_RUN,
      ST_LOCK,
      ST_DONE
   } step_e;

   localparam int ALLBANK_BIT = 10;
   localparam int DLLRST_BIT  = 8;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ddr_pwrup_timer.sv
`timescale 1ns/1ps
module ddr_pwrup_timer #(
   parameter int W       = 8,
   parameter int RST_VAL = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= W'(RST_VAL);
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/ddr_pwrup_lockctr.sv
`timescale 1ns/1ps
module ddr_pwrup_lockctr #(
   parameter int T_DLL = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic ready
);

   localparam int CW = $clog2(T_DLL + 1);

   logic [CW-1:0] cnt;
   logic          running;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         running <= 1'b0;
      end else if (start) begin
         cnt     <= CW'(1);
         running <= 1'b1;
      end else if (running && cnt != CW'(T_DLL)) begin
         cnt     <= cnt + 1'b1;
      end
   end

   // true in the cycle whose closing edge completes the lock window
   assign ready = running && (cnt >= CW'(T_DLL - 1));

endmodule

// File: rtl/ddr_pwrup_modeword.sv
`timescale 1ns/1ps
module ddr_pwrup_modeword
   import ddr_pwrup_pkg::*;
#(
   parameter int ROW_W = 12,
   parameter int BA_W  = 2
) (
   input  step_e            step,
   input  logic [1:0]       cfg_burst_len,
   input  logic             cfg_burst_ilv,
   input  logic [1:0]       cfg_cas_lat,
   input  logic             cfg_drv_weak,
   output cmd_e             cmd,
   output logic [BA_W-1:0]  ba,
   output logic [ROW_W-1:0] addr
);

   logic [2:0]       bl_code;
   logic [2:0]       cl_code;
   logic [ROW_W-1:0] mr_word;

   always_comb begin
      case (cfg_burst_len)
         2'd0:    bl_code = 3'b001;
         2'd1:    bl_code = 3'b010;
         default: bl_code = 3'b011;
      endcase
      case (cfg_cas_lat)
         2'd0:    cl_code = 3'b010;
         2'd1:    cl_code = 3'b110;
         default: cl_code = 3'b011;
      endcase
      mr_word      = '0;
      mr_word[2:0] = bl_code;
      mr_word[3]   = cfg_burst_ilv;
      mr_word[6:4] = cl_code;
   end

   always_comb begin
      cmd  = CMD_NOP;
      ba   = '0;
      addr = '0;
      case (step)
         ST_PRE_A, ST_PRE_B: begin
            cmd               = CMD_PRE;
            addr[ALLBANK_BIT] = 1'b1;
         end
         ST_EMRS: begin
            cmd     = CMD_MRS;
            ba      = BA_W'(1);
            addr[1] = cfg_drv_weak;
            addr[0] = 1'b0;
         end
         ST_MRS_DLLRST: begin
            cmd              = CMD_MRS;
            addr             = mr_word;
            addr[DLLRST_BIT] = 1'b1;
         end
         ST_REF_A, ST_REF_B: cmd = CMD_REF;
         ST_MRS_RUN: begin
            cmd  = CMD_MRS;
            addr = mr_word;
         end
         default: cmd = CMD_NOP;
      endcase
   end

endmodule

// File: rtl/ddr_pwrup_outstage.sv
`timescale 1ns/1ps
module ddr_pwrup_outstage #(
   parameter int ROW_W   = 12,
   parameter int BA_W    = 2,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       cmd_i,
   input  logic             cke_i,
   input  logic [BA_W-1:0]  ba_i,
   input  logic [ROW_W-1:0] addr_i,
   input  logic             done_i,
   output logic [3:0]       cmd_o,
   output logic             cke_o,
   output logic [BA_W-1:0]  ba_o,
   output logic [ROW_W-1:0] addr_o,
   output logic             done_o
);

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cmd_o  <= 4'b0111;
               cke_o  <= 1'b0;
               ba_o   <= '0;
               addr_o <= '0;
               done_o <= 1'b0;
            end else begin
               cmd_o  <= cmd_i;
               cke_o  <= cke_i;
               ba_o   <= ba_i;
               addr_o <= addr_i;
               done_o <= done_i;
            end
         end
      end else begin : g_comb
         assign cmd_o  = cmd_i;
         assign cke_o  = cke_i;
         assign ba_o   = ba_i;
         assign addr_o = addr_i;
         assign done_o = done_i;
      end
   endgenerate

endmodule

// File: rtl/ddr_pwrup_seq.sv
`timescale 1ns/1ps
module ddr_pwrup_seq
   import ddr_pwrup_pkg::*;
#(
   parameter int ROW_W     = 12,
   parameter int BA_W      = 2,
   parameter int T_STABLE  = 200,
   parameter int T_CKE_NOP = 1,
   parameter int T_RP      = 3,
   parameter int T_MRD     = 2,
   parameter int T_RFC     = 10,
   parameter int T_DLL     = 200,
   parameter bit REG_OUT   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       cfg_burst_len,
   input  logic             cfg_burst_ilv,
   input  logic [1:0]       cfg_cas_lat,
   input  logic             cfg_drv_weak,
   output logic             cmd_cs_n,
   output logic             cmd_ras_n,
   output logic             cmd_cas_n,
   output logic             cmd_we_n,
   output logic             mem_cke,
   output logic [BA_W-1:0]  mem_ba,
   output logic [ROW_W-1:0] mem_addr,
   output logic             init_done
);

   localparam int MAX_GAP = max2(max2(T_STABLE, T_CKE_NOP),
                                 max2(max2(T_RP, T_MRD), T_RFC));
   localparam int TW      = $clog2(MAX_GAP + 1);

   generate
      if (ROW_W < 11)    begin : g_bad_row  $error("ROW_W must cover address bit 10"); end
      if (BA_W < 1)      begin : g_bad_ba   $error("BA_W must be at least 1"); end
      if (T_STABLE < 1)  begin : g_bad_stab $error("T_STABLE must be at least 1"); end
      if (T_CKE_NOP < 1) begin : g_bad_cke  $error("T_CKE_NOP must be at least 1"); end
      if (T_RP < 1)      begin : g_bad_rp   $error("T_RP must be at least 1"); end
      if (T_MRD < 2)     begin : g_bad_mrd  $error("T_MRD must be at least 2"); end
      if (T_RFC < 2)     begin : g_bad_rfc  $error("T_RFC must be at least 2"); end
      if (T_DLL < 2)     begin : g_bad_dll  $error("T_DLL must be at least 2"); end
   endgenerate

   step_e            st, st_nxt;
   logic             issue;
   logic             tmr_load, tmr_exp;
   logic [TW-1:0]    tmr_val;
   logic             lock_ready;
   step_e            word_step;
   cmd_e             word_cmd;
   logic [BA_W-1:0]  word_ba;
   logic [ROW_W-1:0] word_addr;

   function automatic int gap_of(input step_e s);
      case (s)
         ST_CKE:                        return T_CKE_NOP;
         ST_PRE_A, ST_PRE_B:            return T_RP;
         ST_EMRS, ST_MRS_DLLRST,
         ST_MRS_RUN:                    return T_MRD;
         ST_REF_A, ST_REF_B:            return T_RFC;
         default:                       return 1;
      endcase
   endfunction

   always_comb begin
      st_nxt = st;
      case (st)
         ST_STABLE:     if (tmr_exp) st_nxt = ST_CKE;
         ST_CKE:        if (tmr_exp) st_nxt = ST_PRE_A;
         ST_PRE_A:      if (tmr_exp) st_nxt = ST_EMRS;
         ST_EMRS:       if (tmr_exp) st_nxt = ST_MRS_DLLRST;
         ST_MRS_DLLRST: if (tmr_exp) st_nxt = ST_PRE_B;
         ST_PRE_B:      if (tmr_exp) st_nxt = ST_REF_A;
         ST_REF_A:      if (tmr_exp) st_nxt = ST_REF_B;
         ST_REF_B:      if (tmr_exp) st_nxt = ST_MRS_RUN;
         ST_MRS_RUN:    if (tmr_exp) st_nxt = lock_ready ? ST_DONE : ST_LOCK;
         ST_LOCK:       if (lock_ready) st_nxt = ST_DONE;
         default:       st_nxt = ST_DONE;
      endcase
   end

   assign tmr_load = (st_nxt != st);
   assign tmr_val  = TW'(gap_of(st_nxt) - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_STABLE;
         issue <= 1'b0;
      end else begin
         st    <= st_nxt;
         issue <= tmr_load;
      end
   end

   ddr_pwrup_timer #(
      .W       (TW),
      .RST_VAL (T_STABLE - 1)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_exp)
   );

   ddr_pwrup_lockctr #(
      .T_DLL (T_DLL)
   ) u_lock (
      .clk   (clk),
      .rst_n (rst_n),
      .start (issue && (st == ST_MRS_DLLRST)),
      .ready (lock_ready)
   );

   // a command is shown only in the first cycle of its step
   assign word_step = issue ? st : ST_STABLE;

   ddr_pwrup_modeword #(
      .ROW_W (ROW_W),
      .BA_W  (BA_W)
   ) u_word (
      .step          (word_step),
      .cfg_burst_len (cfg_burst_len),
      .cfg_burst_ilv (cfg_burst_ilv),
      .cfg_cas_lat   (cfg_cas_lat),
      .cfg_drv_weak  (cfg_drv_weak),
      .cmd           (word_cmd),
      .ba            (word_ba),
      .addr          (word_addr)
   );

   logic [3:0] cmd_out;

   ddr_pwrup_outstage #(
      .ROW_W   (ROW_W),
      .BA_W    (BA_W),
      .REG_OUT (REG_OUT)
   ) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .cmd_i  (word_cmd),
      .cke_i  (st != ST_STABLE),
      .ba_i   (word_ba),
      .addr_i (word_addr),
      .done_i (st == ST_DONE),
      .cmd_o  (cmd_out),
      .cke_o  (mem_cke),
      .ba_o   (mem_ba),
      .addr_o (mem_addr),
      .done_o (init_done)
   );

   assign {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} = cmd_out;

endmodule

// File: rtl/ddr_pwrup_seq_chk.sv
`timescale 1ns/1ps
module ddr_pwrup_seq_chk #(
   parameter int ROW_W = 12,
   parameter int BA_W  = 2,
   parameter int T_DLL = 200
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_cs_n,
   input logic             cmd_ras_n,
   input logic             cmd_cas_n,
   input logic             cmd_we_n,
   input logic             mem_cke,
   input logic [BA_W-1:0]  mem_ba,
   input logic [ROW_W-1:0] mem_addr,
   input logic             init_done
);

   localparam int LW = $clog2(T_DLL + 1);

   logic [3:0] cmd;
   logic       is_nop, is_mrs, is_ref, is_pre, is_emr, is_rst;
   logic [1:0] mrs_cnt;
   logic [LW-1:0] lk_cnt;
   logic       lk_armed;

   assign cmd    = {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};
   assign is_nop = (cmd == 4'b0111);
   assign is_mrs = (cmd == 4'b0000);
   assign is_ref = (cmd == 4'b0001);
   assign is_pre = (cmd == 4'b0010);
   assign is_emr = is_mrs && (mem_ba == BA_W'(1));
   assign is_rst = is_mrs && (mem_ba == '0) && mem_addr[8];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mrs_cnt  <= '0;
         lk_cnt   <= '0;
         lk_armed <= 1'b0;
      end else begin
         if (is_mrs && mrs_cnt != 2'd3) mrs_cnt <= mrs_cnt + 1'b1;
         if (is_rst) begin
            lk_cnt   <= LW'(1);
            lk_armed <= 1'b1;
         end else if (lk_armed && lk_cnt != LW'(T_DLL)) begin
            lk_cnt   <= lk_cnt + 1'b1;
         end
      end
   end

   // R2
   cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_cke |=> mem_cke);

   // R2
   cke_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_cke |-> is_nop);

   // R4
   mrs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_mrs |=> is_nop);

   // R4
   ref_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_ref |=> is_nop);

   // R5
   pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_pre |-> (mem_addr == ROW_W'(1 << 10)));

   // R5
   mrs_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_mrs |-> (mem_ba == '0 || mem_ba == BA_W'(1)));

   // R6
   emr_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_emr |-> ((mem_addr & ~ROW_W'(2)) == '0));

   // R3
   done_after_modes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> (mrs_cnt == 2'd3));

   // R9
   done_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> (lk_armed && lk_cnt == LW'(T_DLL)));

   // R9
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);

   // R9
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> is_nop);

endmodule

bind ddr_pwrup_seq ddr_pwrup_seq_chk #(
   .ROW_W (ROW_W),
   .BA_W  (BA_W),
   .T_DLL (T_DLL)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_cs_n  (cmd_cs_n),
   .cmd_ras_n (cmd_ras_n),
   .cmd_cas_n (cmd_cas_n),
   .cmd_we_n  (cmd_we_n),
   .mem_cke   (mem_cke),
   .mem_ba    (mem_ba),
   .mem_addr  (mem_addr),
   .init_done (init_done)
);

// File: tb/ddr_pwrup_seq_tb.sv
`timescale 1ns/1ps
module ddr_pwrup_seq_tb;

   localparam int ROW_W     = 12;
   localparam int BA_W      = 2;
   localparam int T_STABLE  = 200;
   localparam int T_CKE_NOP = 1;
   localparam int T_RP      = 3;
   localparam int T_MRD     = 2;
   localparam int T_RFC     = 10;
   localparam int T_DLL     = 200;
   localparam int LAT       = 1;

   localparam logic [3:0] NOP = 4'b0111;
   localparam logic [3:0] MRS = 4'b0000;
   localparam logic [3:0] REF = 4'b0001;
   localparam logic [3:0] PRE = 4'b0010;

   typedef struct {
      int               cyc;
      logic [3:0]       cmd;
      logic [BA_W-1:0]  ba;
      logic [ROW_W-1:0] addr;
      string            tag;
   } exp_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [1:0]       cfg_burst_len = 2'd0;
   logic             cfg_burst_ilv = 1'b0;
   logic [1:0]       cfg_cas_lat = 2'd0;
   logic             cfg_drv_weak = 1'b0;
   logic             cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
   logic             mem_cke;
   logic [BA_W-1:0]  mem_ba;
   logic [ROW_W-1:0] mem_addr;
   logic             init_done;

   int   n_tests = 0;
   int   n_fail  = 0;
   bit   finished = 0;
   exp_t q[$];
   bit   mon_on = 0;
   int   n = 0;
   int   exp_cke, exp_done;
   bit   cke_bad, done_bad, stray_bad;
   string cke_msg, done_msg, stray_msg;

   always #2 clk = ~clk;

   ddr_pwrup_seq #(
      .ROW_W (ROW_W), .BA_W (BA_W), .T_STABLE (T_STABLE),
      .T_CKE_NOP (T_CKE_NOP), .T_RP (T_RP), .T_MRD (T_MRD),
      .T_RFC (T_RFC), .T_DLL (T_DLL), .REG_OUT (1'b1)
   ) u_dut (
      .clk (clk), .rst_n (rst_n),
      .cfg_burst_len (cfg_burst_len), .cfg_burst_ilv (cfg_burst_ilv),
      .cfg_cas_lat (cfg_cas_lat), .cfg_drv_weak (cfg_drv_weak),
      .cmd_cs_n (cmd_cs_n), .cmd_ras_n (cmd_ras_n),
      .cmd_cas_n (cmd_cas_n), .cmd_we_n (cmd_we_n),
      .mem_cke (mem_cke), .mem_ba (mem_ba), .mem_addr (mem_addr),
      .init_done (init_done)
   );

   task automatic check(input bit ok, input string req, input string what);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s", req, what);
      end
   endtask

   task automatic push(input int c, input logic [3:0] cm,
                       input logic [BA_W-1:0] b, input logic [ROW_W-1:0] a,
                       input string t);
      exp_t e;
      e.cyc = c; e.cmd = cm; e.ba = b; e.addr = a; e.tag = t;
      q.push_back(e);
   endtask

   // builds the expected timeline from the requirements (R2, R3, R4, R7, R9)
   task automatic plan_run(input logic [1:0] bl, input logic bt,
                           input logic [1:0] cl, input logic drv,
                           input string mr_tag);
      int c_pa, c_em, c_m1, c_pb, c_r1, c_r2, c_m2;
      logic [ROW_W-1:0] mr;
      mr = '0;
      mr[2:0] = (bl == 2'd0) ? 3'b001 : (bl == 2'd1) ? 3'b010 : 3'b011;
      mr[3]   = bt;
      mr[6:4] = (cl == 2'd0) ? 3'b010 : (cl == 2'd1) ? 3'b110 : 3'b011;
      exp_cke = T_STABLE + LAT;
      c_pa = exp_cke + T_CKE_NOP;
      c_em = c_pa + T_RP;
      c_m1 = c_em + T_MRD;
      c_pb = c_m1 + T_MRD;
      c_r1 = c_pb + T_RP;
      c_r2 = c_r1 + T_RFC;
      c_m2 = c_r2 + T_RFC;
      exp_done = (c_m1 + T_DLL > c_m2 + T_MRD) ? c_m1 + T_DLL : c_m2 + T_MRD;
      push(c_pa, PRE, '0, 12'h400, "R3/R4/R5 precharge A");
      push(c_em, MRS, 2'd1, {10'd0, drv, 1'b0}, "R3/R4/R6 ext mode");
      push(c_m1, MRS, '0, mr | 12'h100, {mr_tag, " mode dll-reset"});
      push(c_pb, PRE, '0, 12'h400, "R3/R4/R5 precharge B");
      push(c_r1, REF, '0, '0, "R3/R4 refresh A");
      push(c_r2, REF, '0, '0, "R3/R4 refresh B");
      push(c_m2, MRS, '0, mr, {mr_tag, " mode final"});
   endtask

   // monitor: pops expected commands as the design issues them
   always @(negedge clk) begin
      if (mon_on && rst_n) begin
         logic [3:0] c;
         n++;
         c = {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};
         if (mem_cke !== (n >= exp_cke) && !cke_bad) begin
            cke_bad = 1;
            cke_msg = $sformatf("cke at cycle %0d actual %b expected %b",
                                n, mem_cke, (n >= exp_cke));
         end
         if (init_done !== (n >= exp_done) && !done_bad) begin
            done_bad = 1;
            done_msg = $sformatf("done at cycle %0d actual %b expected %b",
                                 n, init_done, (n >= exp_done));
         end
         if (c !== NOP) begin
            if (q.size() == 0) begin
               if (!stray_bad) begin
                  stray_bad = 1;
                  stray_msg = $sformatf("cycle %0d cmd actual %b expected %b", n, c, NOP);
               end
            end else begin
               exp_t e;
               e = q.pop_front();
               check(c === e.cmd && n == e.cyc, e.tag,
                     $sformatf("cmd/cycle actual %b@%0d expected %b@%0d",
                               c, n, e.cmd, e.cyc));
               check(mem_ba === e.ba && mem_addr === e.addr, e.tag,
                     $sformatf("ba/addr actual %0h/%03h expected %0h/%03h",
                               mem_ba, mem_addr, e.ba, e.addr));
            end
         end
      end
   end

   task automatic do_run(input logic [1:0] bl, input logic bt,
                         input logic [1:0] cl, input logic drv,
                         input string mr_tag);
      rst_n = 1'b0;
      q.delete();
      cfg_burst_len = bl; cfg_burst_ilv = bt; cfg_cas_lat = cl; cfg_drv_weak = drv;
      repeat (3) @(negedge clk);
      // R1: reset values
      check(mem_cke === 1'b0 && {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} === NOP &&
            init_done === 1'b0 && mem_ba === '0 && mem_addr === '0, "R1",
            $sformatf("reset outputs actual cke=%b cmd=%b done=%b ba=%0h addr=%03h expected 0/0111/0/0/000",
                      mem_cke, {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n},
                      init_done, mem_ba, mem_addr));
      plan_run(bl, bt, cl, drv, mr_tag);
      n = 0; cke_bad = 0; done_bad = 0; stray_bad = 0;
      #1;
      mon_on = 1;
      rst_n  = 1'b1;
      repeat (exp_done + 20) @(negedge clk);
      #1;
      mon_on = 0;
      check(!cke_bad, "R2", cke_msg);
      check(!done_bad, "R9", done_msg);
      check(!stray_bad, "R3/R9 NOP between commands", stray_msg);
      check(q.size() == 0, "R3",
            $sformatf("commands left actual %0d expected 0", q.size()));
   endtask

   initial begin
      // BL4 sequential, CL2, normal drive (R7)
      do_run(2'd1, 1'b0, 2'd0, 1'b0, "R7");
      // BL8 interleaved, CL2.5, weak drive (R6, R7)
      do_run(2'd2, 1'b1, 2'd1, 1'b1, "R7");
      // BL2, CL3 code 2
      do_run(2'd0, 1'b0, 2'd2, 1'b0, "R7");
      // unused codes: burst 3 -> 8, latency 3 -> CL3 (R8)
      do_run(2'd3, 1'b1, 2'd3, 1'b1, "R8");
      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      #(4 * 150000);
      if (!finished) begin
         finished = 1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog run did not complete actual timeout expected finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule